// File: doc/BRIEF.md
# DMA Descriptor Address Translator

This block turns an object-relative byte offset into a bus address by walking a 16-byte DMA object descriptor held in a word-addressed descriptor RAM. A client presents the descriptor's word address, an offset and a read/write direction. The block then fetches the flags word, the limit word and one page entry. It returns the translated address and the target memory space of the descriptor, or a fault code.

Two descriptor kinds are handled. A linear descriptor has a single frame entry, and the effective offset is added to that frame. A non-linear descriptor has one entry per 4 KiB page, and the entry is picked by the page index of the effective offset. The effective offset is always the descriptor's 12-bit adjust field plus the request offset. One request is in flight at a time. The descriptor RAM answers a read one cycle after it is issued.

Top module: `dxl_xlate`

## Requirements
- R1: `req_ready` is high only when the block is idle. After a request is accepted, `req_ready` stays low until the response. The response is a single-cycle `rsp_valid` pulse, and `req_ready` is high again in the cycle after it. The descriptor RAM is read at `base`, then at `base+1`, then at most once more for the page entry, and it is never read while the block is idle.
- R2: In the flags word (word 0), bits 31:20 are the adjust field, bits 17:16 the target, bits 15:14 the access mode and bit 13 the linear flag (1 = linear). Bits 12:0 have no effect on the result. `rsp_target` always returns bits 17:16 (0 local memory, 1 local tiled memory, 2 PCI, 3 AGP).
- R3: Word 1 is the limit (byte size minus one). An offset equal to the limit is translated. An offset above it gives `rsp_fault` = 1 with `rsp_addr` = 0, and no page entry is read (two RAM reads in total).
- R4: Access modes are 0 read-write, 1 read-only (a write faults), 2 write-only (a read faults) and 3 (any access faults). An access fault gives `rsp_fault` = 2 with `rsp_addr` = 0 and no page entry read. A limit fault takes precedence over an access fault.
- R5: A page entry with bit 1 clear is read-only. A write through it gives `rsp_fault` = 2 with `rsp_addr` = 0, and a read through it translates normally.
- R6: Non-linear: effective = adjust + offset. The page entry is read from `base + 2 + (effective >> 12)`, and `rsp_addr` = {entry[31:12], effective[11:0]}.
- R7: Linear: the entry is always read from `base + 2`, and `rsp_addr` = {entry[31:12], 12'h000} + effective.
- R8: During and right after reset, `req_ready` is 1, and `rsp_valid` and `mem_rd_en` are 0. `rsp_fault` is 0 on every successful translation.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted this cycle if valid |
| req_base | input | DA_W | Descriptor word address |
| req_offset | input | 32 | Object-relative byte offset |
| req_write | input | 1 | 1 = write access, 0 = read access |
| mem_rd_en | output | 1 | Descriptor RAM read strobe |
| mem_addr | output | DA_W | Descriptor RAM word address |
| mem_rdata | input | 32 | Descriptor RAM data, one cycle after the strobe |
| rsp_valid | output | 1 | Response pulse |
| rsp_addr | output | 32 | Translated bus address, 0 on a fault |
| rsp_target | output | 2 | Target memory space of the descriptor |
| rsp_fault | output | 2 | 0 none, 1 limit, 2 access |

## Verification
The non-linear descriptor is driven with offsets whose page only becomes another page once the adjust field is added, at the exact limit and one byte past it. These requests separate a correct effective-offset sum from a bare offset and `>` from `>=`. The linear descriptors carry a decoy entry at word 3 and a large offset. A design that indexes pages in linear mode returns the decoy frame, and one that ORs instead of adds loses the carry. Every access mode is paired with both directions, including a read-only page under a read-write descriptor and a limit overrun on a read-only descriptor, which exposes the fault priority. The RAM read count per request shows whether the page-entry fetch is skipped on a descriptor fault.

// File: rtl/dxl_pkg.sv
package dxl_pkg;

  // Flags word field positions (decoded by the fetch datapath)
  localparam int W0_ADJ_LSB = 20;
  localparam int W0_ADJ_W   = 12;
  localparam int W0_TGT_LSB = 16;
  localparam int W0_ACC_LSB = 14;
  localparam int W0_LIN_BIT = 13;

  // Page entry layout
  localparam int PG_SHIFT   = 12;
  localparam int FRAME_W    = 32 - PG_SHIFT;
  localparam int PTE_WR_BIT = 1;

  // Word indices inside a descriptor
  localparam int LIMIT_IDX  = 1;
  localparam int ENTRY_IDX  = 2;

  typedef enum logic [1:0] {
    ACC_RW   = 2'd0,
    ACC_RO   = 2'd1,
    ACC_WO   = 2'd2,
    ACC_NONE = 2'd3
  } acc_e;

  typedef enum logic [1:0] {
    FLT_NONE   = 2'd0,
    FLT_LIMIT  = 2'd1,
    FLT_ACCESS = 2'd2,
    FLT_RSVD   = 2'd3
  } flt_e;

  typedef enum logic [2:0] {
    ST_IDLE = 3'd0,
    ST_W0   = 3'd1,
    ST_W1   = 3'd2,
    ST_CHK  = 3'd3,
    ST_PG   = 3'd4,
    ST_RSP  = 3'd5
  } st_e;

endpackage

// File: rtl/dxl_ctrl.sv
module dxl_ctrl
  import dxl_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic req_fire,
  input  logic chk_fault,
  output st_e  state
);

  st_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE: if (req_fire) st_d = ST_W0;
      ST_W0:   st_d = ST_W1;
      ST_W1:   st_d = ST_CHK;
      ST_CHK:  st_d = chk_fault ? ST_RSP : ST_PG;
      ST_PG:   st_d = ST_RSP;
      ST_RSP:  st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) st_q <= ST_IDLE;
    else        st_q <= st_d;
  end

  assign state = st_q;

endmodule

// File: rtl/dxl_check.sv
module dxl_check
  import dxl_pkg::*;
(
  input  acc_e        access,
  input  logic [31:0] limit,
  input  logic [31:0] offset,
  input  logic        is_write,
  input  logic        pte_wr,
  output flt_e        desc_flt,
  output logic        pte_flt
);

  // Limit overrun outranks any permission problem
  always_comb begin
    desc_flt = FLT_NONE;
    if (offset > limit) begin
      desc_flt = FLT_LIMIT;
    end else begin
      unique case (access)
        ACC_RO:   if (is_write)  desc_flt = FLT_ACCESS;
        ACC_WO:   if (!is_write) desc_flt = FLT_ACCESS;
        ACC_NONE: desc_flt = FLT_ACCESS;
        default:  desc_flt = FLT_NONE;
      endcase
    end
  end

  assign pte_flt = is_write && !pte_wr;

endmodule

// File: rtl/dxl_addr_gen.sv
module dxl_addr_gen
  import dxl_pkg::*;
#(
  parameter int DA_W = 16
) (
  input  logic [W0_ADJ_W-1:0] adjust,
  input  logic [31:0]         offset,
  input  logic                linear,
  input  logic [DA_W-1:0]     base,
  input  logic [FRAME_W-1:0]  frame_pn,
  output logic [DA_W-1:0]     pte_addr,
  output logic [31:0]         phys
);

  logic [31:0]     eff;
  logic [31:0]     frame;
  logic [DA_W-1:0] pg_idx;

  assign eff    = offset + {{(32-W0_ADJ_W){1'b0}}, adjust};
  assign frame  = {frame_pn, {PG_SHIFT{1'b0}}};
  assign pg_idx = linear ? '0 : DA_W'(eff >> PG_SHIFT);

  assign pte_addr = base + DA_W'(ENTRY_IDX) + pg_idx;
  assign phys     = linear ? (frame + eff) : {frame_pn, eff[PG_SHIFT-1:0]};

endmodule

// File: rtl/dxl_xlate.sv
module dxl_xlate
  import dxl_pkg::*;
#(
  parameter int DA_W = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            req_valid,
  output logic            req_ready,
  input  logic [DA_W-1:0] req_base,
  input  logic [31:0]     req_offset,
  input  logic            req_write,
  output logic            mem_rd_en,
  output logic [DA_W-1:0] mem_addr,
  input  logic [31:0]     mem_rdata,
  output logic            rsp_valid,
  output logic [31:0]     rsp_addr,
  output logic [1:0]      rsp_target,
  output logic [1:0]      rsp_fault
);

  st_e  state;
  logic req_fire, chk_fault;
  logic req_ld, w0_ld, res_ld;

  // request registers
  logic [DA_W-1:0]     base_q, base_d;
  logic [31:0]         ofs_q, ofs_d;
  logic                wr_q, wr_d;
  // flags word fields
  logic [W0_ADJ_W-1:0] adj_q, adj_d;
  logic [1:0]          tgt_q, tgt_d;
  acc_e                acc_q, acc_d;
  logic                lin_q, lin_d;
  // result registers
  logic [31:0]         res_addr_q, res_addr_d;
  logic [1:0]          res_tgt_q, res_tgt_d;
  flt_e                res_flt_q, res_flt_d;

  flt_e                desc_flt;
  logic                pte_flt;
  logic [DA_W-1:0]     pte_addr;
  logic [31:0]         phys;

  assign req_fire  = req_valid && (state == ST_IDLE);
  assign chk_fault = (desc_flt != FLT_NONE);

  dxl_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_fire  (req_fire),
    .chk_fault (chk_fault),
    .state     (state)
  );

  // Limit word and page entry both arrive on mem_rdata in their own states
  dxl_check u_check (
    .access   (acc_q),
    .limit    (mem_rdata),
    .offset   (ofs_q),
    .is_write (wr_q),
    .pte_wr   (mem_rdata[PTE_WR_BIT]),
    .desc_flt (desc_flt),
    .pte_flt  (pte_flt)
  );

  dxl_addr_gen #(.DA_W(DA_W)) u_agen (
    .adjust   (adj_q),
    .offset   (ofs_q),
    .linear   (lin_q),
    .base     (base_q),
    .frame_pn (mem_rdata[31:PG_SHIFT]),
    .pte_addr (pte_addr),
    .phys     (phys)
  );

  // Clock enables
  assign req_ld = req_fire;
  assign w0_ld  = (state == ST_W1);
  assign res_ld = ((state == ST_CHK) && chk_fault) || (state == ST_PG);

  // Next-state values
  always_comb begin
    base_d = req_base;
    ofs_d  = req_offset;
    wr_d   = req_write;
    adj_d  = mem_rdata[W0_ADJ_LSB +: W0_ADJ_W];
    tgt_d  = mem_rdata[W0_TGT_LSB +: 2];
    acc_d  = acc_e'(mem_rdata[W0_ACC_LSB +: 2]);
    lin_d  = mem_rdata[W0_LIN_BIT];
  end

  always_comb begin
    res_tgt_d  = tgt_q;
    res_addr_d = '0;
    res_flt_d  = desc_flt;
    if (state == ST_PG) begin
      if (pte_flt) begin
        res_flt_d = FLT_ACCESS;
      end else begin
        res_flt_d  = FLT_NONE;
        res_addr_d = phys;
      end
    end
  end

  // Descriptor RAM port
  always_comb begin
    mem_rd_en = 1'b0;
    mem_addr  = base_q;
    unique case (state)
      ST_W0:  mem_rd_en = 1'b1;
      ST_W1: begin
        mem_rd_en = 1'b1;
        mem_addr  = base_q + DA_W'(LIMIT_IDX);
      end
      ST_CHK: begin
        mem_rd_en = !chk_fault;
        mem_addr  = pte_addr;
      end
      default: mem_rd_en = 1'b0;
    endcase
  end

  // Registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      base_q <= '0;
      ofs_q  <= '0;
      wr_q   <= 1'b0;
    end else if (req_ld) begin
      base_q <= base_d;
      ofs_q  <= ofs_d;
      wr_q   <= wr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      adj_q <= '0;
      tgt_q <= '0;
      acc_q <= ACC_RW;
      lin_q <= 1'b0;
    end else if (w0_ld) begin
      adj_q <= adj_d;
      tgt_q <= tgt_d;
      acc_q <= acc_d;
      lin_q <= lin_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_addr_q <= '0;
      res_tgt_q  <= '0;
      res_flt_q  <= FLT_NONE;
    end else if (res_ld) begin
      res_addr_q <= res_addr_d;
      res_tgt_q  <= res_tgt_d;
      res_flt_q  <= res_flt_d;
    end
  end

  assign req_ready  = (state == ST_IDLE);
  assign rsp_valid  = (state == ST_RSP);
  assign rsp_addr   = res_addr_q;
  assign rsp_target = res_tgt_q;
  assign rsp_fault  = res_flt_q;

endmodule

// File: rtl/dxl_xlate_chk.sv
module dxl_xlate_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        req_valid,
  input logic        req_ready,
  input logic        mem_rd_en,
  input logic        rsp_valid,
  input logic [31:0] rsp_addr,
  input logic [1:0]  rsp_fault
);

  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready |=> !req_ready); // R1

  AST_RSP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> !rsp_valid); // R1

  AST_READY_AFTER_RSP: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |=> req_ready); // R1

  AST_NO_READ_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !mem_rd_en); // R1

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && (rsp_fault != 2'd0) |-> rsp_addr == 32'd0); // R3

  AST_FAULT_CODE_KNOWN: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> rsp_fault != 2'd3); // R4

endmodule

bind dxl_xlate dxl_xlate_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .mem_rd_en (mem_rd_en),
  .rsp_valid (rsp_valid),
  .rsp_addr  (rsp_addr),
  .rsp_fault (rsp_fault)
);

// File: tb/sim_dxl_xlate.sv
`timescale 1ns/1ps
module sim_dxl_xlate;

  localparam int DA_W = 16;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            req_valid;
  logic            req_ready;
  logic [DA_W-1:0] req_base;
  logic [31:0]     req_offset;
  logic            req_write;
  logic            mem_rd_en;
  logic [DA_W-1:0] mem_addr;
  logic [31:0]     mem_rdata;
  logic            rsp_valid;
  logic [31:0]     rsp_addr;
  logic [1:0]      rsp_target;
  logic [1:0]      rsp_fault;

  always #10 clk = ~clk; // 50 MHz

  dxl_xlate #(.DA_W(DA_W)) u0 (
    .clk(clk), .rst_n(rst_n),
    .req_valid(req_valid), .req_ready(req_ready),
    .req_base(req_base), .req_offset(req_offset), .req_write(req_write),
    .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
    .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
    .rsp_target(rsp_target), .rsp_fault(rsp_fault)
  );

  // Descriptor RAM model, one-cycle read latency
  logic [31:0] dmem [0:255];
  always @(posedge clk) if (mem_rd_en) mem_rdata <= dmem[mem_addr[7:0]];

  int rd_count = 0;
  always @(posedge clk) if (rst_n && mem_rd_en) rd_count <= rd_count + 1;

  // Scoreboard
  logic [31:0] q_addr [$];
  logic [1:0]  q_tgt  [$];
  logic [1:0]  q_flt  [$];
  int          q_rds  [$];
  string       q_tag  [$];
  int          rd_start = 0;
  int          checks = 0, errors = 0;
  int          rst_checks = 0, rst_errs = 0;

  always @(negedge clk) begin
    if (rst_n === 1'b1 && rsp_valid === 1'b1) begin
      if (q_addr.size() == 0) begin
        checks = checks + 1;
        errors = errors + 1;
        $display("FAIL R1 unexpected response addr=%h", rsp_addr);
      end else begin
        logic [31:0] ea;
        logic [1:0]  et, ef;
        int          er, ar;
        string       tg;
        ea = q_addr.pop_front(); et = q_tgt.pop_front();
        ef = q_flt.pop_front();  er = q_rds.pop_front();
        tg = q_tag.pop_front();
        ar = rd_count - rd_start;
        checks = checks + 1;
        if (rsp_addr !== ea || rsp_target !== et || rsp_fault !== ef) begin
          errors = errors + 1;
          $display("FAIL %s actual addr=%h tgt=%0d flt=%0d expected addr=%h tgt=%0d flt=%0d",
                   tg, rsp_addr, rsp_target, rsp_fault, ea, et, ef);
        end
        checks = checks + 1;
        if (ar != er) begin
          errors = errors + 1;
          $display("FAIL %s R1 ram reads actual=%0d expected=%0d", tg, ar, er);
        end
      end
    end
  end

  task automatic send(input logic [DA_W-1:0] b, input logic [31:0] o, input logic w,
                      input logic [31:0] ea, input logic [1:0] et, input logic [1:0] ef,
                      input int er, input string tag);
    @(negedge clk);
    while (req_ready !== 1'b1) @(negedge clk);
    rd_start = rd_count;
    q_addr.push_back(ea); q_tgt.push_back(et); q_flt.push_back(ef);
    q_rds.push_back(er);  q_tag.push_back(tag);
    req_valid  = 1'b1;
    req_base   = b;
    req_offset = o;
    req_write  = w;
    @(negedge clk);
    req_valid  = 1'b0;
    while (q_addr.size() != 0) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks + rst_checks + 1, errors + rst_errs + 1);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) dmem[i] = 32'd0;
    // A: non-linear, read-write, local, adjust 0x010, limit 0x2FFF
    dmem[16] = 32'h0100_103D; dmem[17] = 32'h0000_2FFF;
    dmem[18] = 32'h0001_0002; dmem[19] = 32'h0002_5002;
    dmem[20] = 32'h0003_A000; dmem[21] = 32'h0004_B002;
    // B: linear, read-only, AGP, adjust 0xABC, limit 0xFFFF, decoy at word 3
    dmem[32] = 32'hABC3_7002; dmem[33] = 32'h0000_FFFF;
    dmem[34] = 32'h0080_0002; dmem[35] = 32'hDEAD_0002;
    // C: linear, write-only, PCI, adjust 0, limit 0xFFF
    dmem[48] = 32'h0002_B000; dmem[49] = 32'h0000_0FFF;
    dmem[50] = 32'h1234_5002;
    // D: linear, no access, tiled, adjust 1, limit 0xFF
    dmem[64] = 32'h0011_F000; dmem[65] = 32'h0000_00FF;
    dmem[66] = 32'h0000_1002;
    // E: non-linear, read-write, tiled, low bits all set except bit 12
    dmem[80] = 32'h0001_0FFF; dmem[81] = 32'h0000_1FFF;
    dmem[82] = 32'h0007_0002; dmem[83] = 32'h0009_0000;

    rst_n = 1'b0; req_valid = 1'b0; req_base = '0; req_offset = '0; req_write = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    rst_checks = rst_checks + 1; // R8
    if (req_ready !== 1'b1 || rsp_valid !== 1'b0 || mem_rd_en !== 1'b0) begin
      rst_errs = rst_errs + 1;
      $display("FAIL R8 reset state actual ready=%b valid=%b rd=%b expected 1 0 0",
               req_ready, rsp_valid, mem_rd_en);
    end

    send(16, 32'h0000_0000, 0, 32'h0001_0010, 0, 0, 3, "R6 first page");
    send(16, 32'h0000_1FF0, 0, 32'h0003_A000, 0, 0, 3, "R6 adjust carries into page 2");
    send(16, 32'h0000_0FF0, 1, 32'h0002_5000, 0, 0, 3, "R5 write to writable page");
    send(16, 32'h0000_2000, 1, 32'h0000_0000, 0, 2, 3, "R5 write to read-only page");
    send(16, 32'h0000_2000, 0, 32'h0003_A010, 0, 0, 3, "R5 read of read-only page");
    send(16, 32'h0000_2FFF, 0, 32'h0004_B00F, 0, 0, 3, "R3 offset equal to limit");
    send(16, 32'h0000_3000, 0, 32'h0000_0000, 0, 1, 2, "R3 offset past limit");
    send(32, 32'h0000_5000, 0, 32'h0080_5ABC, 3, 0, 3, "R7 linear add");
    send(32, 32'h0000_FFFF, 0, 32'h0081_0ABB, 3, 0, 3, "R7 linear ignores page index");
    send(32, 32'h0000_0000, 1, 32'h0000_0000, 3, 2, 2, "R4 write to read-only descriptor");
    send(32, 32'h0001_0000, 1, 32'h0000_0000, 3, 1, 2, "R4 limit outranks access");
    send(48, 32'h0000_0123, 1, 32'h1234_5123, 2, 0, 3, "R4 write to write-only descriptor");
    send(48, 32'h0000_0123, 0, 32'h0000_0000, 2, 2, 2, "R4 read from write-only descriptor");
    send(64, 32'h0000_0000, 0, 32'h0000_0000, 1, 2, 2, "R4 read with mode 3");
    send(64, 32'h0000_0000, 1, 32'h0000_0000, 1, 2, 2, "R4 write with mode 3");
    send(80, 32'h0000_1004, 0, 32'h0009_0004, 1, 0, 3, "R2 low flag bits ignored");
    send(80, 32'h0000_1004, 1, 32'h0000_0000, 1, 2, 3, "R5 write to read-only page 1");
    send(80, 32'h0000_0FFF, 1, 32'h0007_0FFF, 1, 0, 3, "R2 page 0 end");

    repeat (4) @(negedge clk);
    rst_checks = rst_checks + 1;
    if (q_addr.size() != 0) begin
      rst_errs = rst_errs + 1;
      $display("FAIL R1 missing responses actual=%0d expected=0", q_addr.size());
    end
    $display("CHECKS %0d ERRORS %0d", checks + rst_checks, errors + rst_errs);
    $finish;
  end

endmodule